// File: doc/BRIEF.md
# Burst Transfer Target on a Shared Address/Data Bus

This block is the responding side of a synchronous bus on which the address and the data share one set of lines. An initiator opens a transaction by raising a cycle-active strobe. On that same clock edge it presents a command code and a start word address. After that edge the same lines carry data words. Each word moves only on a rising edge where both the initiator's ready and the target's ready are high. Bursts may run for any number of words, and the word address steps by one after every completed word.

The target holds a small word memory. A write burst stores words into it, and a read burst returns words from it. On a read, the target leaves the shared lines undriven for one turnaround cycle before it drives them. To model a slow internal buffer, the target drops its ready for a fixed number of cycles after every group of transfers. The initiator marks the final word by dropping cycle-active while that word is still pending. Once that word completes, the target goes idle and releases both its ready and its drive.

Top module: `burst_tgt`

## Requirements
- R1: After reset, `tgt_ready` and `adbus_drive` are low, `adbus_out` is zero, and every memory word reads as zero.
- R2: When the target is idle, a rising edge with `cyc_active` high is the address phase. On that edge the target latches `cmd_code`, and it takes the start word address from the low log2(DEPTH) bits of `adbus_in`.
- R3: Command code 4'h6 means read and 4'h7 means write. Any other code is ignored: `tgt_ready` and `adbus_drive` stay low, memory is unchanged, and the target returns to idle once `cyc_active` is low.
- R4: A word transfers only on a rising edge where `ini_ready` and `tgt_ready` are both high. Any other edge changes neither memory nor the word address.
- R5: After each transfer the word address advances by one, wrapping modulo DEPTH.
- R6: The transfer that completes with `cyc_active` low is the last one. In the following cycle the target is idle, with `tgt_ready` and `adbus_drive` low.
- R7: On a read, the cycle after the address phase is a turnaround with `adbus_drive` and `tgt_ready` low. The target drives `adbus_out` with the addressed word from the next cycle on.
- R8: Within a transaction, after every CHUNK-th transfer that is not the last one, `tgt_ready` is low for exactly WAIT_CYC cycles. Over a burst of n words this gives WAIT_CYC*floor((n-1)/CHUNK) target wait cycles.
- R9: A burst has no length limit. No word is lost or duplicated across initiator or target wait states.
- R10: Words written by a write burst are returned unchanged by a later read burst of the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_active | input | 1 | Initiator cycle strobe; low while the final word is pending |
| ini_ready | input | 1 | Initiator ready for the current data word |
| cmd_code | input | 4 | Command code, sampled in the address phase |
| adbus_in | input | DW | Shared lines as seen by the target (address, then write data) |
| tgt_ready | output | 1 | Target ready for the current data word |
| adbus_out | output | DW | Read data driven by the target |
| adbus_drive | output | 1 | Target enables its drive of the shared lines |

## Verification
The bound checker watches five things on every cycle. Writes happen only on a dual-ready edge. Each non-final transfer steps the address by one. After a read address phase comes a silent turnaround, and drive begins right after it. Everything is released after the final word. An ignored command never produces ready, drive or a write. The wait-state count, the memory contents after mixed random bursts, and the absence of lost or repeated words can only be shown by the bench's scenarios. In those scenarios a bench model memory is compared word by word during reads whose initiator stalls are drawn at random.

// File: rtl/burst_tgt_pkg.sv
`timescale 1ns/1ps
package burst_tgt_pkg;
  localparam logic [3:0] CMD_RD = 4'h6;
  localparam logic [3:0] CMD_WR = 4'h7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2,
    ST_IGNR = 2'd3
  } tgt_state_e;
endpackage

// File: rtl/burst_tgt_mem.sv
`timescale 1ns/1ps
module burst_tgt_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) store[k] <= '0;
    end else if (wr_en) begin
      store[idx] <= wdata;
    end
  end

  assign rdata = store[idx];
endmodule

// File: rtl/burst_tgt_ctrl.sv
`timescale 1ns/1ps
module burst_tgt_ctrl
  import burst_tgt_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CHUNK    = 4,
  parameter int WAIT_CYC = 2,
  localparam int IW      = $clog2(DEPTH),
  localparam int CW      = $clog2(CHUNK + 1),
  localparam int SW      = $clog2(WAIT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_active,
  input  logic          ini_ready,
  input  logic [3:0]    cmd_code,
  input  logic [IW-1:0] start_idx,
  output logic          tgt_ready,
  output logic          adbus_drive,
  output logic [IW-1:0] word_idx,
  output logic          xfer,
  output logic          last_xfer,
  output logic          in_turn,
  output logic          ignoring,
  output logic          busy,
  output logic          rd_mode
);
  tgt_state_e    state;
  logic [CW-1:0] chunk_cnt;
  logic [SW-1:0] stall_cnt;

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] cur);
    return IW'(cur + 1'b1);
  endfunction

  function automatic logic group_done(input logic [CW-1:0] cnt);
    return (int'(cnt) == CHUNK - 1);
  endfunction

  assign tgt_ready   = (state == ST_DATA) && (stall_cnt == '0);
  assign adbus_drive = (state == ST_DATA) && rd_mode;
  assign xfer        = tgt_ready && ini_ready;
  assign last_xfer   = xfer && !cyc_active;
  assign in_turn     = (state == ST_TURN);
  assign ignoring    = (state == ST_IGNR);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      word_idx  <= '0;
      rd_mode   <= 1'b0;
      chunk_cnt <= '0;
      stall_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cyc_active) begin
            word_idx  <= start_idx;
            chunk_cnt <= '0;
            stall_cnt <= '0;
            rd_mode   <= (cmd_code == CMD_RD);
            if (cmd_code == CMD_RD)      state <= ST_TURN;
            else if (cmd_code == CMD_WR) state <= ST_DATA;
            else                         state <= ST_IGNR;
          end
        end
        ST_TURN: state <= ST_DATA;
        ST_DATA: begin
          if (xfer) begin
            word_idx <= step_idx(word_idx);
            if (!cyc_active) begin
              state <= ST_IDLE;
            end else if (group_done(chunk_cnt)) begin
              chunk_cnt <= '0;
              stall_cnt <= SW'(WAIT_CYC);
            end else begin
              chunk_cnt <= CW'(chunk_cnt + 1'b1);
            end
          end else if (stall_cnt != '0) begin
            stall_cnt <= SW'(stall_cnt - 1'b1);
          end
        end
        ST_IGNR: if (!cyc_active) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_tgt.sv
`timescale 1ns/1ps
module burst_tgt #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int CHUNK    = 4,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_active,
  input  logic          ini_ready,
  input  logic [3:0]    cmd_code,
  input  logic [DW-1:0] adbus_in,
  output logic          tgt_ready,
  output logic [DW-1:0] adbus_out,
  output logic          adbus_drive
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] word_idx;
  logic          xfer, last_xfer, in_turn, ignoring, busy, rd_mode, wr_en;
  logic [DW-1:0] rdata;

  burst_tgt_ctrl #(.DEPTH(DEPTH), .CHUNK(CHUNK), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .ini_ready(ini_ready),
    .cmd_code(cmd_code), .start_idx(adbus_in[IW-1:0]),
    .tgt_ready(tgt_ready), .adbus_drive(adbus_drive), .word_idx(word_idx),
    .xfer(xfer), .last_xfer(last_xfer), .in_turn(in_turn),
    .ignoring(ignoring), .busy(busy), .rd_mode(rd_mode)
  );

  assign wr_en = xfer && !rd_mode;

  burst_tgt_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(word_idx),
    .wdata(adbus_in), .rdata(rdata)
  );

  assign adbus_out = adbus_drive ? rdata : '0;
endmodule

// File: rtl/burst_tgt_chk.sv
`timescale 1ns/1ps
module burst_tgt_chk
  import burst_tgt_pkg::*;
#(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_active,
  input logic          ini_ready,
  input logic [3:0]    cmd_code,
  input logic          tgt_ready,
  input logic          adbus_drive,
  input logic [IW-1:0] word_idx,
  input logic          xfer,
  input logic          last_xfer,
  input logic          in_turn,
  input logic          ignoring,
  input logic          busy,
  input logic          rd_mode,
  input logic          wr_en
);
  assert_write_dual_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (tgt_ready && ini_ready && !rd_mode));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer && !in_turn) |=> (word_idx == $past(word_idx)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last_xfer) |=> (word_idx == IW'($past(word_idx) + 1'b1)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> (!busy && !tgt_ready && !adbus_drive));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cyc_active && cmd_code == CMD_RD) |=> (in_turn && !adbus_drive && !tgt_ready));

  assert_drive_after_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |=> adbus_drive);

  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> (!tgt_ready && !adbus_drive && !wr_en));
endmodule

bind burst_tgt burst_tgt_chk #(.IW(IW)) u_chk (.*);

// File: tb/burst_tgt_tb.sv
`timescale 1ns/1ps
module burst_tgt_tb;
  localparam int DW = 32, DEPTH = 16, CHUNK = 4, WAIT_CYC = 2;
  localparam logic [3:0] RD = 4'h6, WR = 4'h7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_active = 1'b0, ini_ready = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic [DW-1:0] adbus_in = '0;
  logic tgt_ready, adbus_drive;
  logic [DW-1:0] adbus_out;

  always #2.5 clk = ~clk;

  burst_tgt #(.DW(DW), .DEPTH(DEPTH), .CHUNK(CHUNK), .WAIT_CYC(WAIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .ini_ready(ini_ready),
    .cmd_code(cmd_code), .adbus_in(adbus_in), .tgt_ready(tgt_ready),
    .adbus_out(adbus_out), .adbus_drive(adbus_drive)
  );

  logic [DW-1:0] model [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int exp_waits(input int n);
    return WAIT_CYC * ((n - 1) / CHUNK);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic burst(input logic [3:0] cmd, input int start, input int n, input int pct);
    int i = 0, idx = start % DEPTH, low = 0, guard = 0;
    bit seen = 0;
    @(negedge clk);
    cyc_active = 1; cmd_code = cmd; adbus_in = DW'(start); ini_ready = 0;
    @(negedge clk);
    if (cmd == RD)
      check(!adbus_drive && !tgt_ready, "R7 turnaround", {30'b0, adbus_drive, tgt_ready}, '0);
    while (i < n && guard < 2000) begin
      bit ib = (($urandom % 100) < pct);
      logic [DW-1:0] d = $urandom;
      ini_ready = ib;
      cyc_active = !(ib && i == n - 1);
      adbus_in = d;
      if (tgt_ready) seen = 1;
      else if (seen) low++;
      if (ib && tgt_ready) begin
        if (cmd == RD) check(adbus_drive && adbus_out == model[idx], "R10/R9 read word", adbus_out, model[idx]);
        else model[idx] = d;
        idx = (idx + 1) % DEPTH;
        i++;
      end
      @(negedge clk);
      guard++;
    end
    cyc_active = 0; ini_ready = 0;
    check(!tgt_ready && !adbus_drive, "R6 release", {30'b0, adbus_drive, tgt_ready}, '0);
    check(low == exp_waits(n), "R8 wait count", DW'(low), DW'(exp_waits(n)));
  endtask

  task automatic ignored(input logic [3:0] cmd, input int start);
    @(negedge clk);
    cyc_active = 1; cmd_code = cmd; adbus_in = DW'(start); ini_ready = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ini_ready = 1; cyc_active = (k < 3); adbus_in = $urandom;
      check(!tgt_ready && !adbus_drive, "R3 ignored cmd quiet", {30'b0, adbus_drive, tgt_ready}, '0);
    end
    @(negedge clk);
    ini_ready = 0; cyc_active = 0;
    check(!tgt_ready, "R3 back to idle", DW'(tgt_ready), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    check(!tgt_ready && !adbus_drive && adbus_out == '0, "R1 reset outputs", adbus_out, '0);
    rst_n = 1;
    burst(RD, 5, 3, 100);                 // R1 memory zero after reset
    burst(WR, 2, 1, 100);                 // R2 single word write
    burst(RD, 2, 1, 100);
    burst(WR, 10, 20, 100);               // R5 wrap, R8 stalls
    burst(RD, 10, 20, 60);                // R9 initiator waits
    ignored(4'h3, 0);                     // R3 ignored codes
    ignored(4'hF, 10);
    burst(RD, 0, DEPTH, 100);             // R3 memory unchanged
    for (int r = 0; r < 20; r++) begin
      logic [3:0] c = ($urandom % 2) ? RD : WR;
      burst(c, int'($urandom % DEPTH), 1 + int'($urandom % 12), 40 + int'($urandom % 61));
    end
    burst(RD, 0, 2 * DEPTH, 70);          // R4 final sweep
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule